// File: doc/BRIEF.md
# Semi-Synchronous Bus Cycle Sequencer

This block is the bus-master side of a semi-synchronous parallel bus. It takes one transfer request at a time: an address, write data, a read/write direction and a memory-or-I/O space bit. It then steps the bus through four clock states, T1, T2, T3 and T4. When the addressed device is slow, it adds wait states between T3 and T4. The strobes and qualifiers for external latches and transceivers come from the current state. At the end of each transfer the block returns the read data and raises a one-clock completion pulse.

The device stretches a transfer by holding `ready_i` low. The block first samples `ready_i` when T2 ends. After that it samples it again at the end of each wait state. Read data is captured at the single edge that closes the data phase.

The block has two reset paths. `rst_n` is the asynchronous power-on reset. `cpu_reset_i` is a system reset request, and it counts only after it has been held long enough. After either reset the block starts on its own with a memory read from the fixed start-up address.

Top module: `bus_cycle_seq`

## Requirements
- R1: With `ready_i` high at the end of T2, a transfer occupies exactly four clocks (T1, T2, T3, T4). `done_o` is high for the single T4 clock only.
- R2: In T1, `ale_o` is high for one clock and `addr_o` carries the request address. `dt_o` (1 = write, 0 = read) and `mio_o` (1 = memory, 0 = I/O) take the request's values and hold them for the whole transfer.
- R3: From T2 through the last wait state, `den_o` is high and exactly one of `rd_o` (read) or `wr_o` (write) is high. For a write, `dout_en_o` is high and `dout_o` carries the write data over the same span.
- R4: `ready_i` is sampled only at the end of T2 to decide whether waits follow T3. Its value at the end of T1 or T3 has no effect on cycle length.
- R5: Each wait state lasts one clock. `ready_i` is sampled again at the end of every wait state, and each low sample adds one more wait. N waits lengthen a transfer to 4+N clocks.
- R6: For a read, `din_i` is captured at the end of T3 when there are no waits, otherwise at the end of the last wait. The captured value appears on `rdata_o` from T4 on and is held unchanged through later writes until the next read capture.
- R7: In T4, `ale_o`, `rd_o`, `wr_o`, `den_o` and `dout_en_o` are all low.
- R8: `req_ready_o` is high only in the idle state or in T4. A request presented at other times is ignored. A request accepted in T4 starts its T1 on the very next clock.
- R9: `cpu_reset_i` takes effect only when it is high on 4 consecutive rising clock edges. A pulse of 3 clocks changes nothing. Once the reset is qualified, every bus strobe drops from the next clock onward and `req_ready_o` stays low while the input remains high. Any transfer in progress is abandoned.
- R10: After `rst_n` is released, and after a qualified `cpu_reset_i` is released, the block runs a memory read at address 0xFFFF0 without any request. Requests are accepted from that read's T4 onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cpu_reset_i | input | 1 | System reset request; must be held 4 clocks |
| req_valid_i | input | 1 | Transfer request present |
| req_ready_o | output | 1 | Request accepted this clock (idle or T4) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_mem_i | input | 1 | 1 = memory space, 0 = I/O space |
| req_addr_i | input | AW | Transfer address |
| req_wdata_i | input | DW | Write data |
| ready_i | input | 1 | Device ready; low requests wait states |
| din_i | input | DW | Read data from the bus |
| addr_o | output | AW | Bus address, valid with `ale_o` |
| ale_o | output | 1 | Address latch strobe (T1) |
| rd_o | output | 1 | Read strobe, active high |
| wr_o | output | 1 | Write strobe, active high |
| den_o | output | 1 | Data transceiver enable |
| dt_o | output | 1 | Transceiver direction, 1 = transmit |
| mio_o | output | 1 | 1 = memory, 0 = I/O |
| dout_o | output | DW | Write data to the bus |
| dout_en_o | output | 1 | Write data drive enable |
| rdata_o | output | DW | Captured read data |
| done_o | output | 1 | One-clock pulse in T4 |

## Verification
Transfers are run with 0, 1, 2 and 3 wait states, in both directions and in both spaces. Some start from idle and some are chained in T4, which separates correct T3 and wait timing from off-by-one errors. `ready_i` is deliberately driven the wrong way at the end of T3, and `din_i` carries a complement pattern on every clock except the capture edge. A wrong sample point therefore shows up as a wrong cycle length or a wrong `rdata_o`. Reset pulses of three and of more than four clocks, one landing mid-transfer in a wait state, separate the hold-time qualification from a plain level-triggered reset and confirm the start-up read at 0xFFFF0.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [2:0] {
    S_RST  = 3'd0,
    S_IDLE = 3'd1,
    S_T1   = 3'd2,
    S_T2   = 3'd3,
    S_T3   = 3'd4,
    S_TW   = 3'd5,
    S_T4   = 3'd6
  } bus_state_e;
endpackage

// File: rtl/bcs_rst_qual.sv
// Qualifies the system reset request: it counts only once the input has
// been high on HOLD consecutive rising edges.
module bcs_rst_qual #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_reset_i,
  output logic rst_take_o
);
  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LIM = CW'(HOLD - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!cpu_reset_i)      cnt_d = '0;
    else if (cnt_q != LIM) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // The current edge is the HOLD-th consecutive high sample.
  assign rst_take_o = cpu_reset_i && (cnt_q == LIM);

  // R9: a qualified reset is always preceded by a high input one edge earlier
  assert_hold_history_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_take_o && HOLD > 1 && cnt_q != '0) |-> $past(cpu_reset_i));
endmodule

// File: rtl/bcs_fsm.sv
// Cycle state machine: T1, T2, T3, waits, T4, plus reset and idle.
module bcs_fsm
  import bcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rst_take_i,
  input  logic       req_valid_i,
  input  logic       ready_i,
  output bus_state_e state_o,
  output logic       accept_o,
  output logic       boot_load_o,
  output logic       cap_o,
  output logic       req_ready_o
);
  bus_state_e state_q, state_d;
  logic       ready_q;
  logic       ready_en;

  assign req_ready_o = ((state_q == S_IDLE) || (state_q == S_T4)) && !rst_take_i;
  assign accept_o    = req_ready_o && req_valid_i;
  assign boot_load_o = (state_q == S_RST) && !rst_take_i;
  assign cap_o       = !rst_take_i &&
                       (((state_q == S_T3) && ready_q) || ((state_q == S_TW) && ready_i));
  assign ready_en    = (state_q == S_T2);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_RST:   state_d = S_T1;
      S_IDLE:  state_d = accept_o ? S_T1 : S_IDLE;
      S_T1:    state_d = S_T2;
      S_T2:    state_d = S_T3;
      S_T3:    state_d = ready_q ? S_T4 : S_TW;
      S_TW:    state_d = ready_i ? S_T4 : S_TW;
      S_T4:    state_d = accept_o ? S_T1 : S_IDLE;
      default: state_d = S_IDLE;
    endcase
    if (rst_take_i) state_d = S_RST;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_RST;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ready_en) ready_q <= ready_i;
    end
  end

  assign state_o = state_q;

  // R1: T1 always leads into T2
  assert_t1_to_t2_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_T1 && !rst_take_i) |=> (state_q == S_T2));
  // R4: a low sample at the end of T2 forces a wait after T3
  assert_t3_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_T3 && !ready_q && !rst_take_i) |=> (state_q == S_TW));
  // R4: a high sample at the end of T2 goes straight to T4
  assert_t3_direct_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_T3 && ready_q && !rst_take_i) |=> (state_q == S_T4));
  // R5: another wait follows every low sample in a wait state
  assert_wait_repeat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_TW && !ready_i && !rst_take_i) |=> (state_q == S_TW));
  // R9: a qualified reset request moves the machine to reset
  assert_reset_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_take_i |=> (state_q == S_RST));
  // R8: no new transfer starts out of the data phase
  assert_no_midstart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q inside {S_T1, S_T2, S_T3, S_TW}) |=> (state_q != S_T1));
endmodule

// File: rtl/bcs_datapath.sv
// Holds the transfer in flight and decodes the bus strobes from the state.
module bcs_datapath
  import bcs_pkg::*;
#(
  parameter int            AW        = 20,
  parameter int            DW        = 16,
  parameter logic [AW-1:0] RESET_VEC = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bus_state_e    state_i,
  input  logic          accept_i,
  input  logic          boot_load_i,
  input  logic          cap_i,
  input  logic          req_write_i,
  input  logic          req_mem_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [DW-1:0] din_i,
  output logic [AW-1:0] addr_o,
  output logic          ale_o,
  output logic          rd_o,
  output logic          wr_o,
  output logic          den_o,
  output logic          dt_o,
  output logic          mio_o,
  output logic [DW-1:0] dout_o,
  output logic          dout_en_o,
  output logic [DW-1:0] rdata_o,
  output logic          done_o
);
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] wdata_q, wdata_d;
  logic          write_q, write_d;
  logic          mem_q, mem_d;
  logic [DW-1:0] rdata_q;
  logic          load_en;
  logic          rcap_en;
  logic          data_ph;

  assign load_en = accept_i || boot_load_i;
  assign rcap_en = cap_i && !write_q;

  always_comb begin
    addr_d  = req_addr_i;
    wdata_d = req_wdata_i;
    write_d = req_write_i;
    mem_d   = req_mem_i;
    if (boot_load_i) begin
      addr_d  = RESET_VEC;
      wdata_d = '0;
      write_d = 1'b0;
      mem_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      mem_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (load_en) begin
        addr_q  <= addr_d;
        wdata_q <= wdata_d;
        write_q <= write_d;
        mem_q   <= mem_d;
      end
      if (rcap_en) rdata_q <= din_i;
    end
  end

  assign data_ph   = (state_i == S_T2) || (state_i == S_T3) || (state_i == S_TW);
  assign addr_o    = addr_q;
  assign ale_o     = (state_i == S_T1);
  assign rd_o      = data_ph && !write_q;
  assign wr_o      = data_ph && write_q;
  assign den_o     = data_ph;
  assign dt_o      = write_q;
  assign mio_o     = mem_q;
  assign dout_o    = wdata_q;
  assign dout_en_o = data_ph && write_q;
  assign rdata_o   = rdata_q;
  assign done_o    = (state_i == S_T4);

  // R2: address and qualifiers hold from T1 to the end of the transfer
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i inside {S_T2, S_T3, S_TW, S_T4}) |-> ($stable(addr_q) && $stable(write_q)));
  // R1: completion is a single-clock pulse
  assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R6: read data moves only at the close of the data phase
  assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i inside {S_IDLE, S_T1, S_T2, S_T4, S_RST}) |=> $stable(rdata_q));
  // R3: the strobes never overlap
  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_o && wr_o));
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int            AW        = 20,
  parameter int            DW        = 16,
  parameter int            RST_HOLD  = 4,
  parameter logic [AW-1:0] RESET_VEC = AW'(20'hFFFF0)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_reset_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic          req_mem_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic          ready_i,
  input  logic [DW-1:0] din_i,
  output logic [AW-1:0] addr_o,
  output logic          ale_o,
  output logic          rd_o,
  output logic          wr_o,
  output logic          den_o,
  output logic          dt_o,
  output logic          mio_o,
  output logic [DW-1:0] dout_o,
  output logic          dout_en_o,
  output logic [DW-1:0] rdata_o,
  output logic          done_o
);
  bus_state_e state;
  logic       rst_take;
  logic       accept;
  logic       boot_load;
  logic       cap;

  bcs_rst_qual #(.HOLD(RST_HOLD)) i_rst_qual (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_reset_i (cpu_reset_i),
    .rst_take_o  (rst_take)
  );

  bcs_fsm i_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .rst_take_i  (rst_take),
    .req_valid_i (req_valid_i),
    .ready_i     (ready_i),
    .state_o     (state),
    .accept_o    (accept),
    .boot_load_o (boot_load),
    .cap_o       (cap),
    .req_ready_o (req_ready_o)
  );

  bcs_datapath #(.AW(AW), .DW(DW), .RESET_VEC(RESET_VEC)) i_datapath (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_i     (state),
    .accept_i    (accept),
    .boot_load_i (boot_load),
    .cap_i       (cap),
    .req_write_i (req_write_i),
    .req_mem_i   (req_mem_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .din_i       (din_i),
    .addr_o      (addr_o),
    .ale_o       (ale_o),
    .rd_o        (rd_o),
    .wr_o        (wr_o),
    .den_o       (den_o),
    .dt_o        (dt_o),
    .mio_o       (mio_o),
    .dout_o      (dout_o),
    .dout_en_o   (dout_en_o),
    .rdata_o     (rdata_o),
    .done_o      (done_o)
  );

  // R7: every strobe is quiet while the transfer completes
  assert_t4_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !(ale_o || rd_o || wr_o || den_o || dout_en_o));
  // R3: the address strobe is followed by the data phase
  assert_ale_then_den_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ale_o && !rst_take) |=> (den_o && !ale_o));
endmodule

// File: tb/test_bus_cycle_seq.sv
module test_bus_cycle_seq;
  typedef struct packed {
    logic        w;
    logic        m;
    logic [19:0] a;
    logic [15:0] wd;
    logic [3:0]  n;
    logic [15:0] din;
    logic        b2b;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 1'b1, 20'h12345, 16'h0000, 4'd0, 16'hA1B2, 1'b0},
    '{1'b1, 1'b1, 20'h00400, 16'h5A5A, 4'd0, 16'h0000, 1'b0},
    '{1'b0, 1'b0, 20'h00060, 16'h0000, 4'd1, 16'h0F0F, 1'b0},
    '{1'b1, 1'b0, 20'h003F8, 16'hC3C3, 4'd2, 16'h0000, 1'b0},
    '{1'b0, 1'b1, 20'hABCDE, 16'h0000, 4'd3, 16'h7E81, 1'b0},
    '{1'b1, 1'b1, 20'h00001, 16'hFFFF, 4'd0, 16'h0000, 1'b1},
    '{1'b0, 1'b1, 20'h80000, 16'h0000, 4'd2, 16'h1234, 1'b1},
    '{1'b0, 1'b0, 20'h000FF, 16'h0000, 4'd0, 16'h00FF, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_reset_i;
  logic        req_valid_i;
  logic        req_ready_o;
  logic        req_write_i;
  logic        req_mem_i;
  logic [19:0] req_addr_i;
  logic [15:0] req_wdata_i;
  logic        ready_i;
  logic [15:0] din_i;
  logic [19:0] addr_o;
  logic        ale_o, rd_o, wr_o, den_o, dt_o, mio_o, dout_en_o, done_o;
  logic [15:0] dout_o;
  logic [15:0] rdata_o;

  int          checks = 0;
  int          errors = 0;
  logic        finished = 1'b0;
  logic [15:0] exp_rdata = 16'h0000;

  always #10 clk = ~clk;

  bus_cycle_seq i_bus_cycle_seq (
    .clk (clk), .rst_n (rst_n), .cpu_reset_i (cpu_reset_i),
    .req_valid_i (req_valid_i), .req_ready_o (req_ready_o),
    .req_write_i (req_write_i), .req_mem_i (req_mem_i),
    .req_addr_i (req_addr_i), .req_wdata_i (req_wdata_i),
    .ready_i (ready_i), .din_i (din_i),
    .addr_o (addr_o), .ale_o (ale_o), .rd_o (rd_o), .wr_o (wr_o),
    .den_o (den_o), .dt_o (dt_o), .mio_o (mio_o), .dout_o (dout_o),
    .dout_en_o (dout_en_o), .rdata_o (rdata_o), .done_o (done_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] ctrl();
    return {ale_o, rd_o, wr_o, den_o, dout_en_o, done_o};
  endfunction

  task automatic drive_req(input vec_t v);
    req_valid_i = 1'b1;
    req_write_i = v.w;
    req_mem_i   = v.m;
    req_addr_i  = v.a;
    req_wdata_i = v.wd;
  endtask

  // Runs one transfer. When start is set, the request is driven at the current
  // negative edge. When chain is set, nx is presented in T4.
  task automatic do_xfer(input vec_t v, input logic start, input logic chain, input vec_t nx);
    int n;
    int cap_c;
    logic dph;
    n = int'(v.n);
    cap_c = (n == 0) ? 3 : 3 + n;
    if (start) begin
      drive_req(v);
      chk("R8 ready when idle", {31'd0, req_ready_o}, 32'd1);
    end
    for (int c = 1; c <= 4 + n; c++) begin
      @(negedge clk);
      if (c == 1) req_valid_i = 1'b0;
      dph = (c >= 2) && (c <= 3 + n);
      chk((c == 1) ? "R2 T1 strobes" : (c == 4 + n) ? "R7 R1 T4 strobes" : "R3 R4 R5 data phase",
          {26'd0, ctrl()},
          {26'd0, (c == 1), dph && !v.w, dph && v.w, dph, dph && v.w, (c == 4 + n)});
      if (c == 1) begin
        chk("R2 address", {12'd0, addr_o}, {12'd0, v.a});
        chk("R2 qualifiers", {30'd0, dt_o, mio_o}, {30'd0, v.w, v.m});
      end
      if (c == 2 && v.w) chk("R3 write data", {16'd0, dout_o}, {16'd0, v.wd});
      if (c == 3 + n) chk("R2 qualifiers held", {30'd0, dt_o, mio_o}, {30'd0, v.w, v.m});
      if (c == 4 + n) begin
        if (!v.w) exp_rdata = v.din;
        chk("R6 read data", {16'd0, rdata_o}, {16'd0, exp_rdata});
        chk("R8 ready in T4", {31'd0, req_ready_o}, 32'd1);
      end
      // Ready: the decisive samples are the end of T2 and the end of each wait.
      // The end of T3 is driven to the opposite value to show it is ignored (R4).
      if (c == 2)      ready_i = (n == 0);
      else if (c == 3) ready_i = (n > 0);
      else if (c >= 4) ready_i = (c == 3 + n);
      else             ready_i = 1'b0;
      din_i = (c == cap_c) ? v.din : ~v.din;
      if (c == 4 + n && chain) drive_req(nx);
    end
    ready_i = 1'b0;
    if (!chain) begin
      @(negedge clk);
      chk("R8 back to idle", {25'd0, req_ready_o, ctrl()}, {25'd0, 1'b1, 6'd0});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    vec_t boot;
    vec_t none;
    vec_t v;
    boot = '{1'b0, 1'b1, 20'hFFFF0, 16'h0000, 4'd0, 16'hBEEF, 1'b0};
    none = '0;
    rst_n = 1'b0; cpu_reset_i = 1'b0; req_valid_i = 1'b0; req_write_i = 1'b0;
    req_mem_i = 1'b0; req_addr_i = '0; req_wdata_i = '0; ready_i = 1'b0; din_i = '0;

    repeat (3) @(negedge clk);
    chk("R9 reset state", {25'd0, req_ready_o, ctrl()}, 32'd0);
    chk("R6 reset rdata", {16'd0, rdata_o}, 32'd0);
    rst_n = 1'b1;
    // R10: start-up read at 0xFFFF0 with no request
    do_xfer(boot, 1'b0, 1'b0, none);

    // Table of transfers, some chained in T4 (R8)
    for (int i = 0; i < NV; i++) begin
      logic ch;
      ch = (i + 1 < NV) ? TBL[i + 1].b2b : 1'b0;
      do_xfer(TBL[i], !TBL[i].b2b, ch, (i + 1 < NV) ? TBL[i + 1] : none);
    end

    // R8: a request raised during T2 is ignored
    v = '{1'b0, 1'b1, 20'h0AAAA, 16'h0000, 4'd0, 16'h4444, 1'b0};
    drive_req(v);
    @(negedge clk); req_valid_i = 1'b0; ready_i = 1'b1;
    @(negedge clk);
    chk("R8 not ready in T2", {31'd0, req_ready_o}, 32'd0);
    req_valid_i = 1'b1; req_addr_i = 20'h05555;
    @(negedge clk); req_valid_i = 1'b0; din_i = 16'h4444; ready_i = 1'b0;
    @(negedge clk);
    chk("R6 T2-ignored read data", {16'd0, rdata_o}, 32'h4444);
    exp_rdata = 16'h4444;
    @(negedge clk);
    chk("R8 T2 request dropped", {26'd0, ctrl()}, 32'd0);
    @(negedge clk);
    chk("R8 still idle", {26'd0, ctrl()}, 32'd0);

    // R9: a three-clock reset pulse has no effect
    cpu_reset_i = 1'b1;
    repeat (3) @(negedge clk);
    cpu_reset_i = 1'b0;
    @(negedge clk);
    chk("R9 short pulse idle", {25'd0, req_ready_o, ctrl()}, {25'd0, 1'b1, 6'd0});
    @(negedge clk);
    chk("R9 short pulse no boot", {26'd0, ctrl()}, 32'd0);
    v = '{1'b0, 1'b0, 20'h00321, 16'h0000, 4'd1, 16'h6006, 1'b0};
    do_xfer(v, 1'b1, 1'b0, none);

    // R9: a long reset abandons a transfer stuck in wait states
    v = '{1'b0, 1'b1, 20'h22222, 16'h0000, 4'd0, 16'h0000, 1'b0};
    drive_req(v);
    ready_i = 1'b0;
    @(negedge clk); req_valid_i = 1'b0;
    @(negedge clk);
    chk("R9 in T2 before reset", {31'd0, rd_o}, 32'd1);
    cpu_reset_i = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 under 4 samples keeps cycle", {31'd0, rd_o}, 32'd1);
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 qualified reset quiet", {25'd0, req_ready_o, ctrl()}, 32'd0);
    end
    cpu_reset_i = 1'b0;
    // R10: start-up read again after the reset request drops
    boot.din = 16'h0DAD;
    boot.n = 4'd1;
    do_xfer(boot, 1'b0, 1'b0, none);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule